// File: doc/BRIEF.md
# DMA transmit FIFO request controller

This block paces DMA write requests that carry one outgoing frame into a 128-byte transmit FIFO organised as two 64-byte halves. Software first loads a 12-bit length value through a low-byte write and a high-nibble write. It then issues a transmit command. From that point the block runs without further processor help. It raises `dma_req` whenever the half it is filling is empty. It counts each accepted byte and closes a block after 64 bytes or after the frame's final byte. It also tags the final byte with an end-of-frame bit.

The programmed value is the length minus one, so a frame is 1 to 4096 bytes long. A frame moves as a run of full 64-byte blocks followed by one shorter remainder block. The block sizes that remainder itself. A length that is an exact multiple of 64 has no remainder block. A serial-side drain port reads committed blocks out in write order and frees each half after its last byte. Frames follow one another. Each frame needs its own length setup and its own command once the previous frame has been fully written.

Top module: `dmatx_req_ctrl`

## Requirements
- R1: A `cnt_lo_we` write loads length bits 7:0 from `cnt_wdata[7:0]`. A `cnt_hi_we` write loads length bits 11:8 from `cnt_wdata[3:0]`, and `cnt_wdata[7:4]` is ignored. A frame is the loaded value plus one byte long, so lengths run from 1 to 4096.
- R2: A one-cycle `tx_cmd` while idle starts a frame. When the fill half is empty, `dma_req` is high in the cycle after the command.
- R3: A frame accepts exactly its length in bytes, a byte being accepted on a clock edge where both `dma_wr` and `dma_req` are high. `dma_wr` while `dma_req` is low stores nothing.
- R4: Bytes are grouped into 64-byte blocks, with the last block holding the remaining 1 to 64 bytes. `dma_req` falls at the edge that accepts a block's last byte and stays low for at least one cycle. Each high period of `dma_req` therefore carries exactly one block.
- R5: `dma_req` starts a block only while the half being filled is empty. When both halves hold data, the request waits until the drain side frees one.
- R6: `drain_valid` is high while a committed block is held. A `drain_rd` with `drain_valid` high pops one byte, and bytes come out in the order they were written. A `drain_rd` with `drain_valid` low has no effect.
- R7: `drain_eof` is high on the frame's last byte and on no other byte.
- R8: `tx_done` is a one-cycle pulse in the cycle after the edge that accepts the frame's last byte.
- R9: A `tx_cmd` while a frame is still being filled does not change that frame's length, and it sets `cmd_err`. `cmd_err` stays set until reset.
- R10: A synchronous active-low `rst_n` empties both halves, ends any frame, clears `cmd_err` and `tx_done`, and drops `dma_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_lo_we | input | 1 | Load length bits 7:0 |
| cnt_hi_we | input | 1 | Load length bits 11:8 |
| cnt_wdata | input | 8 | Length write data |
| tx_cmd | input | 1 | Transmit command pulse |
| dma_req | output | 1 | DMA write request |
| dma_wr | input | 1 | DMA write strobe |
| dma_data | input | 8 | DMA write byte |
| drain_rd | input | 1 | Drain-side pop |
| drain_valid | output | 1 | A committed byte is available |
| drain_data | output | 8 | Byte at the drain head |
| drain_eof | output | 1 | Head byte is the frame's last |
| tx_done | output | 1 | Pulse after the frame's last byte is written |
| cmd_err | output | 1 | Sticky flag for a command issued while busy |

## Verification
Two functions can act in the same clock edge. The DMA side can commit one half with its closing byte on the same edge that the drain side pops the last byte of the other half and frees it. The bench provokes this with a deliberately slowed drain on multi-block frames. In that case both halves fill, the request stalls, and drain pops coincide with block closures. The bench keeps its own count of committed and freed halves and judges each rising request against it. It also checks that every byte and the end-of-frame tag come out in order, with no block lost or duplicated.

// File: rtl/dmatx_pkg.sv
// Package: shared defaults for the DMA transmit FIFO request controller.
// Assumes: the FIFO always has exactly two halves; per-half depth is a power of two.
package dmatx_pkg;
    localparam int unsigned NUM_HALVES     = 2;
    localparam int unsigned DEF_HALF_DEPTH = 64;
    localparam int unsigned DEF_DATA_W     = 8;
    localparam int unsigned DEF_CNT_W      = 12;
endpackage

// File: rtl/dmatx_count.sv
// Module: dmatx_count
// Holds the programmed length, counts the bytes still owed for the current
// frame, and produces busy, last-byte, done and command-error indications.
// Assumes: CNT_W > DATA_W; wr_fire is only asserted while a frame is open.
module dmatx_count #(
    parameter int unsigned CNT_W  = dmatx_pkg::DEF_CNT_W,
    parameter int unsigned DATA_W = dmatx_pkg::DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lo_we,
    input  logic              hi_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              cmd,
    input  logic              wr_fire,
    output logic              busy,
    output logic              last_byte,
    output logic              done,
    output logic              err
);
    localparam int unsigned REM_W = CNT_W + 1;
    localparam int unsigned HI_W  = CNT_W - DATA_W;

    logic [CNT_W-1:0] cnt_q;
    logic [REM_W-1:0] rem_q;
    logic             busy_q;
    logic             done_q;
    logic             err_q;

    // Length register: low byte and high part written separately.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            if (lo_we) cnt_q[DATA_W-1:0]     <= wdata;
            if (hi_we) cnt_q[CNT_W-1:DATA_W] <= wdata[HI_W-1:0];
        end
    end

    // Frame sequencing: start on command, count down per byte, flag misuse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (cmd && busy_q) err_q <= 1'b1;
            if (cmd && !busy_q) begin
                rem_q  <= REM_W'(cnt_q) + REM_W'(1);
                busy_q <= 1'b1;
            end else if (wr_fire && busy_q) begin
                rem_q <= rem_q - REM_W'(1);
                if (rem_q == REM_W'(1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign busy      = busy_q;
    assign last_byte = busy_q && (rem_q == REM_W'(1));
    assign done      = done_q;
    assign err       = err_q;

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);
    // R9
    busy_cmd_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd && busy_q) |=> err_q);
    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    // R3
    rem_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (rem_q != '0));
endmodule

// File: rtl/dmatx_fifo.sv
// Module: dmatx_fifo
// Two-half transmit store. The write side fills one half at a time and
// commits it on its 64th byte or on the frame's last byte. The drain side
// pops committed halves in order and frees each after its last byte.
// Assumes: HALF_DEPTH is a power of two; wr_en only while fill half is empty.
module dmatx_fifo #(
    parameter int unsigned HALF_DEPTH = dmatx_pkg::DEF_HALF_DEPTH,
    parameter int unsigned DATA_W     = dmatx_pkg::DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_eof,
    output logic              fill_full,
    output logic              blk_gap,
    input  logic              rd_en,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_eof
);
    localparam int unsigned HALVES = dmatx_pkg::NUM_HALVES;
    localparam int unsigned IDX_W  = $clog2(HALF_DEPTH);
    localparam int unsigned LEN_W  = IDX_W + 1;
    localparam int unsigned DEPTH  = HALVES * HALF_DEPTH;

    logic [DATA_W:0]  mem_q [DEPTH];
    logic             full_q [HALVES];
    logic [LEN_W-1:0] len_q [HALVES];
    logic             fill_half_q;
    logic [IDX_W-1:0] wr_idx_q;
    logic             rd_half_q;
    logic [IDX_W-1:0] rd_idx_q;
    logic             gap_q;
    logic             blk_last;
    logic             rd_fire;
    logic             rd_last;

    assign blk_last = wr_eof || (wr_idx_q == IDX_W'(HALF_DEPTH - 1));
    assign rd_fire  = rd_en && rd_valid;
    assign rd_last  = (LEN_W'(rd_idx_q) + LEN_W'(1)) == len_q[rd_half_q];

    // Storage write: byte plus end-of-frame tag.
    always_ff @(posedge clk) begin
        if (wr_en) mem_q[{fill_half_q, wr_idx_q}] <= {wr_eof, wr_data};
    end

    // Write pointer: advance per byte, switch halves when a block closes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_half_q <= 1'b0;
            wr_idx_q    <= '0;
            gap_q       <= 1'b0;
        end else begin
            gap_q <= wr_en && blk_last;
            if (wr_en) begin
                if (blk_last) begin
                    wr_idx_q    <= '0;
                    fill_half_q <= ~fill_half_q;
                end else begin
                    wr_idx_q <= wr_idx_q + IDX_W'(1);
                end
            end
        end
    end

    // Read pointer: advance per pop, move on after a block's last byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_half_q <= 1'b0;
            rd_idx_q  <= '0;
        end else if (rd_fire) begin
            if (rd_last) begin
                rd_idx_q  <= '0;
                rd_half_q <= ~rd_half_q;
            end else begin
                rd_idx_q <= rd_idx_q + IDX_W'(1);
            end
        end
    end

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        // Per-half occupancy: set on block commit, cleared when drained.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                full_q[h] <= 1'b0;
                len_q[h]  <= '0;
            end else if (wr_en && blk_last && (fill_half_q == 1'(h))) begin
                full_q[h] <= 1'b1;
                len_q[h]  <= LEN_W'(wr_idx_q) + LEN_W'(1);
            end else if (rd_fire && rd_last && (rd_half_q == 1'(h))) begin
                full_q[h] <= 1'b0;
            end
        end
    end

    assign fill_full          = full_q[fill_half_q];
    assign blk_gap            = gap_q;
    assign rd_valid           = full_q[rd_half_q];
    assign {rd_eof, rd_data}  = mem_q[{rd_half_q, rd_idx_q}];

    // R5
    no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !full_q[fill_half_q]);
    // R4
    gap_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gap_q |-> !wr_en);
    // R6
    drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_valid) |=> ($stable(rd_idx_q) && $stable(rd_half_q)));
endmodule

// File: rtl/dmatx_req_ctrl.sv
// Module: dmatx_req_ctrl (top)
// Joins the length/frame counter and the two-half store, and forms the DMA
// request: open frame, fill half empty, and not the cycle right after a
// block closed.
// Assumes: the DMA master writes only while dma_req is high.
module dmatx_req_ctrl #(
    parameter int unsigned HALF_DEPTH = dmatx_pkg::DEF_HALF_DEPTH,
    parameter int unsigned DATA_W     = dmatx_pkg::DEF_DATA_W,
    parameter int unsigned CNT_W      = dmatx_pkg::DEF_CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_lo_we,
    input  logic              cnt_hi_we,
    input  logic [DATA_W-1:0] cnt_wdata,
    input  logic              tx_cmd,
    output logic              dma_req,
    input  logic              dma_wr,
    input  logic [DATA_W-1:0] dma_data,
    input  logic              drain_rd,
    output logic              drain_valid,
    output logic [DATA_W-1:0] drain_data,
    output logic              drain_eof,
    output logic              tx_done,
    output logic              cmd_err
);
    logic busy;
    logic last_byte;
    logic fill_full;
    logic blk_gap;
    logic wr_fire;

    assign dma_req = busy && !fill_full && !blk_gap;
    assign wr_fire = dma_wr && dma_req;

    dmatx_count #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .lo_we     (cnt_lo_we),
        .hi_we     (cnt_hi_we),
        .wdata     (cnt_wdata),
        .cmd       (tx_cmd),
        .wr_fire   (wr_fire),
        .busy      (busy),
        .last_byte (last_byte),
        .done      (tx_done),
        .err       (cmd_err)
    );

    dmatx_fifo #(.HALF_DEPTH(HALF_DEPTH), .DATA_W(DATA_W)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_fire),
        .wr_data   (dma_data),
        .wr_eof    (last_byte),
        .fill_full (fill_full),
        .blk_gap   (blk_gap),
        .rd_en     (drain_rd),
        .rd_valid  (drain_valid),
        .rd_data   (drain_data),
        .rd_eof    (drain_eof)
    );

    // R8
    done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> $past(wr_fire));
endmodule

// File: tb/dmatx_req_ctrl_tb.sv
module dmatx_req_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_lo_we = 1'b0;
    logic       cnt_hi_we = 1'b0;
    logic [7:0] cnt_wdata = '0;
    logic       tx_cmd = 1'b0;
    logic       dma_req;
    logic       dma_wr = 1'b0;
    logic [7:0] dma_data = '0;
    logic       drain_rd = 1'b0;
    logic       drain_valid;
    logic [7:0] drain_data;
    logic       drain_eof;
    logic       tx_done;
    logic       cmd_err;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    dmatx_req_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cnt_lo_we(cnt_lo_we), .cnt_hi_we(cnt_hi_we),
        .cnt_wdata(cnt_wdata), .tx_cmd(tx_cmd), .dma_req(dma_req), .dma_wr(dma_wr),
        .dma_data(dma_data), .drain_rd(drain_rd), .drain_valid(drain_valid),
        .drain_data(drain_data), .drain_eof(drain_eof), .tx_done(tx_done),
        .cmd_err(cmd_err)
    );

    // Vectors: length, expected bursts, expected last burst size, slow drain
    localparam int NVEC = 9;
    localparam int VEC [NVEC][4] = '{
        '{36, 1, 36, 0}, '{104, 2, 40, 0}, '{1, 1, 1, 0},
        '{64, 1, 64, 0}, '{65, 2, 1, 0},   '{128, 2, 64, 0},
        '{200, 4, 8, 1}, '{300, 5, 44, 1}, '{4096, 64, 64, 0}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int len, input int i);
        return 8'((i * 7 + len * 3) & 255);
    endfunction

    // R1: low byte then high nibble (upper nibble garbage), then command (R2)
    task automatic start_frame(input int len);
        int v = len - 1;
        @(negedge clk);
        cnt_lo_we = 1'b1; cnt_wdata = v[7:0];
        @(negedge clk);
        cnt_lo_we = 1'b0; cnt_hi_we = 1'b1; cnt_wdata = {4'hA, v[11:8]};
        @(negedge clk);
        cnt_hi_we = 1'b0; tx_cmd = 1'b1;
        @(negedge clk);
        tx_cmd = 1'b0;
    endtask

    task automatic run_frame(input int len, input int exp_b, input int exp_last,
                             input bit slow, input bit inject);
        int wr_n = 0, rd_n = 0, bursts = 0, cur = 0, last_sz = 0;
        int bad_full = 0, data_err = 0, eof_err = 0, done_n = 0, done_bad = 0;
        int drained = 0, r5_err = 0, cyc = 0, lw_cyc = -10, extra = 0;
        bit prev_req = 1'b0, injected = 1'b0;
        start_frame(len);
        check(dma_req == 1'b1, "R2", "request after command", int'(dma_req), 1);
        while ((wr_n < len || rd_n < len) && cyc < 20000) begin
            dma_wr = 1'b0; drain_rd = 1'b0; tx_cmd = 1'b0;
            if (tx_done) begin
                done_n++;
                if (cyc != lw_cyc + 1) done_bad++;
            end
            if (dma_req) begin
                if (!prev_req && (bursts - drained) >= 2) r5_err++;
                dma_wr = 1'b1; dma_data = pat(len, wr_n);
                wr_n++; cur++;
                if (wr_n == len) lw_cyc = cyc;
            end else if (prev_req) begin
                bursts++;
                if (cur != 64 && wr_n < len) bad_full++;
                last_sz = cur; cur = 0;
            end
            prev_req = dma_req;
            if (drain_valid && (!slow || (cyc % 4) == 0)) begin
                drain_rd = 1'b1;
                if (drain_data != pat(len, rd_n)) data_err++;
                if (drain_eof != (rd_n == len - 1)) eof_err++;
                rd_n++;
                if ((rd_n % 64) == 0 || rd_n == len) drained++;
            end
            if (inject && !injected && wr_n == 10) begin
                tx_cmd = 1'b1; injected = 1'b1;
            end
            cyc++;
            @(negedge clk);
        end
        dma_wr = 1'b0; drain_rd = 1'b0; tx_cmd = 1'b0;
        for (int k = 0; k < 8; k++) begin
            if (dma_req || drain_valid || tx_done) extra++;
            @(negedge clk);
        end
        check(wr_n == len, "R3", "bytes accepted", wr_n, len);
        check(extra == 0, "R3", "activity after frame", extra, 0);
        check(rd_n == len && data_err == 0, "R6", "drained bytes in order", data_err, 0);
        check(eof_err == 0, "R7", "end-of-frame tag placement", eof_err, 0);
        check(bursts == exp_b, "R4", "request bursts", bursts, exp_b);
        check(last_sz == exp_last, "R4", "remainder block size", last_sz, exp_last);
        check(bad_full == 0, "R4", "non-final blocks of 64", bad_full, 0);
        check(r5_err == 0, "R5", "request with both halves full", r5_err, 0);
        check(done_n == 1 && done_bad == 0, "R8", "done pulse timing", done_n, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int wn;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check(dma_req == 1'b0, "R10", "req after reset", int'(dma_req), 0);
        check(drain_valid == 1'b0, "R10", "valid after reset", int'(drain_valid), 0);
        check(tx_done == 1'b0, "R10", "done after reset", int'(tx_done), 0);
        check(cmd_err == 1'b0, "R10", "err after reset", int'(cmd_err), 0);

        // R3: stray writes while idle store nothing
        dma_wr = 1'b1; dma_data = 8'h5A;
        repeat (3) @(negedge clk);
        dma_wr = 1'b0;
        check(drain_valid == 1'b0, "R3", "stray write stored", int'(drain_valid), 0);

        // R1 R4 R5 R6 R7 R8: vector table
        for (int i = 0; i < NVEC; i++)
            run_frame(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3][0], 1'b0);
        check(cmd_err == 1'b0, "R9", "no error on clean frames", int'(cmd_err), 0);

        // R9: command during fill ignored, flag sticky
        run_frame(100, 2, 36, 1'b0, 1'b1);
        check(cmd_err == 1'b1, "R9", "error flag set", int'(cmd_err), 1);
        run_frame(20, 1, 20, 1'b0, 1'b0);
        check(cmd_err == 1'b1, "R9", "error flag sticky", int'(cmd_err), 1);

        // R10: reset in mid-frame
        start_frame(300);
        wn = 0;
        for (int k = 0; k < 80; k++) begin
            dma_wr = dma_req;
            dma_data = pat(300, wn);
            if (dma_req) wn++;
            @(negedge clk);
        end
        dma_wr = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(dma_req == 1'b0, "R10", "req after mid-frame reset", int'(dma_req), 0);
        check(drain_valid == 1'b0, "R10", "halves empty after reset", int'(drain_valid), 0);
        check(cmd_err == 1'b0, "R10", "err cleared by reset", int'(cmd_err), 0);
        run_frame(36, 1, 36, 1'b0, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule